// File: doc/BRIEF.md
# Outer-Product Integer Matrix Accumulate Unit

This block is a small matrix engine for integer neural-network inference. One command brings in two 128-bit operands, each a 4x4 grid of signed 8-bit values, and forms in one step every cross product between the row groups of the first operand and the row groups of the second. The sixteen resulting dot products update a 4x4 block of signed 32-bit accumulators. The accumulators can be cleared first, or the products can be added to what they already hold. A loop can therefore walk down long weight and activation arrays one 16-byte slice per operand per command.

Commands enter through a valid/ready port with a 2-bit opcode. An update takes two cycles to reach the accumulators, and the port stalls while it is in flight. A read command streams the accumulator block out as four 128-bit rows on consecutive cycles. The port reopens during the last row, so the next update can be accepted without a bubble.

Top module: `opa_mac_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every accumulator becomes zero, `rd_valid` becomes low and `cmd_ready` becomes high.
- R2: Operand byte (g,k), with g and k in 0..3, sits at bits 8*(4*g+k)+7 down to 8*(4*g+k) and is a two's-complement signed value.
- R3: Opcode 0 sets accumulator (i,j) to the sum over k of X[i][k]*Y[j][k].
- R4: Opcode 1 adds the same sum to the value accumulator (i,j) already holds.
- R5: Products and sums are 32-bit signed and wrap in two's complement on overflow.
- R6: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both high. After an update (opcode 0 or 1) is accepted at edge T, `cmd_ready` is low until edge T+2, and the new accumulator values are in place for any command accepted from then on.
- R7: Opcode 2 drives rows 0, 1, 2 and 3 in the four cycles after the accepting edge, one per cycle, with `rd_valid` high and `rd_row` giving the row index. Element j of row i is in bits 32*j+31 down to 32*j of `rd_data`.
- R8: `cmd_ready` is low during read-out rows 0 to 2 and may be high during row 3. An update accepted during row 3 does not change the row-3 data and is applied normally.
- R9: Opcode 3 is accepted but does nothing: no read-out starts, and the accumulators keep their values. A read command does not change the accumulators either.
- R10: A `cmd_valid` pulse while `cmd_ready` is low is ignored and leaves the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 2 | 0 clear-and-add, 1 add, 2 read, 3 no operation |
| cmd_x | input | 128 | Operand X, 4 groups of 4 signed bytes |
| cmd_y | input | 128 | Operand Y, 4 groups of 4 signed bytes |
| rd_valid | output | 1 | A read-out row is on `rd_data` |
| rd_row | output | 2 | Index of the row on `rd_data` |
| rd_data | output | 128 | Accumulator row, 4 signed 32-bit elements |

## Verification
The overlap that matters is the last read-out beat and the acceptance of the next update, which fall in the same cycle. The bench makes this happen every time a read is followed by another command: it issues the next command in the row-3 cycle as soon as `cmd_ready` rises. Row 3 is compared against the model state from before that update, and the following read must show the update applied exactly once.

// File: rtl/opa_pkg.sv
// Package: shared constants and command encoding for the outer-product
// accumulate unit. Assumes a square grid of N groups of N lanes.
package opa_pkg;

    parameter int unsigned OPA_N  = 4;   // groups per operand and lanes per group
    parameter int unsigned OPA_EW = 8;   // operand element width
    parameter int unsigned OPA_AW = 32;  // accumulator element width

    typedef enum logic [1:0] {
        OPC_ZERO_ADD = 2'd0,
        OPC_ADD      = 2'd1,
        OPC_READ     = 2'd2,
        OPC_NOP      = 2'd3
    } opa_opc_e;

endpackage

// File: rtl/opa_dot_lane.sv
// Module: one signed dot product of N element pairs, widened to AW bits.
// Purely combinational. Assumes AW is wider than a single product
// (2*EW bits), so each product is sign-extended before it is summed.
module opa_dot_lane #(
    parameter int unsigned N  = 4,
    parameter int unsigned EW = 8,
    parameter int unsigned AW = 32
) (
    input  logic [N*EW-1:0] a_i,
    input  logic [N*EW-1:0] b_i,
    output logic [AW-1:0]   dot_o
);

    localparam int unsigned PW = 2 * EW;

    logic signed [PW-1:0] prod [N];
    logic        [AW-1:0] acc_sum;

    // Multiply each pair of signed elements at full product width.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            prod[k] = $signed(a_i[k*EW +: EW]) * $signed(b_i[k*EW +: EW]);
        end
    end

    // Sign-extend the products and add them into one AW-bit result.
    always_comb begin
        acc_sum = '0;
        for (int k = 0; k < N; k++) begin
            acc_sum = acc_sum + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
        end
    end

    assign dot_o = acc_sum;

endmodule

// File: rtl/opa_grid_stage.sv
// Module: forms all N*N cross dot products between the row groups of X
// and the row groups of Y, and registers them together with the
// clear flag. Element (i,j) of the grid is X group i against Y group j.
// Assumes take_i is only raised for an accepted update command.
module opa_grid_stage #(
    parameter int unsigned N  = 4,
    parameter int unsigned EW = 8,
    parameter int unsigned AW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take_i,
    input  logic                      clear_i,
    input  logic [N*N*EW-1:0]         x_i,
    input  logic [N*N*EW-1:0]         y_i,
    output logic                      valid_o,
    output logic                      clear_o,
    output logic [N*N-1:0][AW-1:0]    dot_o
);

    localparam int unsigned GW = N * EW;   // bits per operand group

    logic [N*N-1:0][AW-1:0] dot_w;

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            opa_dot_lane #(
                .N  (N),
                .EW (EW),
                .AW (AW)
            ) u_lane (
                .a_i   (x_i[gi*GW +: GW]),
                .b_i   (y_i[gj*GW +: GW]),
                .dot_o (dot_w[gi*N + gj])
            );
        end
    end

    // Track whether a product grid is waiting to be written back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= take_i;
        end
    end

    // Capture the product grid and the clear request of an accepted update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_o <= 1'b0;
            dot_o   <= '0;
        end else if (take_i) begin
            clear_o <= clear_i;
            dot_o   <= dot_w;
        end
    end

endmodule

// File: rtl/opa_acc_bank.sv
// Module: the N*N accumulator registers. On a write each element takes
// either its product alone (clear) or its old value plus the product.
// Arithmetic wraps at AW bits. Assumes wr_i lasts one cycle per update.
module opa_acc_bank #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   clear_i,
    input  logic [N*N-1:0][AW-1:0] dot_i,
    output logic [N*N-1:0][AW-1:0] acc_o
);

    for (genvar ge = 0; ge < N*N; ge++) begin : g_elem
        // Hold one accumulator element: reset, replace or add.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_o[ge] <= '0;
            end else if (wr_i) begin
                acc_o[ge] <= (clear_i ? '0 : acc_o[ge]) + dot_i[ge];
            end
        end
    end

endmodule

// File: rtl/opa_readout.sv
// Module: streams the accumulator block out one row per cycle, row 0
// first. A start during the final row restarts the stream at row 0.
// Assumes the caller only starts a stream when no update is pending.
module opa_readout #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [N*N-1:0][AW-1:0]    acc_i,
    output logic                      active_o,
    output logic                      last_o,
    output logic [$clog2(N)-1:0]      row_o,
    output logic [N*AW-1:0]           data_o
);

    localparam int unsigned RW       = $clog2(N);
    localparam logic [RW-1:0] LASTROW = RW'(N - 1);

    // Sequence the row counter through one full pass per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            row_o    <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            row_o    <= '0;
        end else if (active_o) begin
            if (row_o == LASTROW) begin
                active_o <= 1'b0;
                row_o    <= '0;
            end else begin
                row_o <= row_o + 1'b1;
            end
        end
    end

    assign last_o = active_o && (row_o == LASTROW);

    // Select the current row; drive zero between streams.
    always_comb begin
        data_o = '0;
        if (active_o) begin
            data_o = acc_i[row_o*N +: N];
        end
    end

endmodule

// File: rtl/opa_mac_unit.sv
// Module: top of the outer-product accumulate unit. Decodes the command
// port, feeds accepted updates through the product stage into the
// accumulator bank, and hands read commands to the row streamer.
// Assumes commands are held stable while cmd_valid is high and not yet
// accepted. Updates take effect two edges after acceptance.
module opa_mac_unit
    import opa_pkg::*;
#(
    parameter int unsigned N  = OPA_N,
    parameter int unsigned EW = OPA_EW,
    parameter int unsigned AW = OPA_AW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_op,
    input  logic [N*N*EW-1:0]      cmd_x,
    input  logic [N*N*EW-1:0]      cmd_y,
    output logic                   rd_valid,
    output logic [$clog2(N)-1:0]   rd_row,
    output logic [N*AW-1:0]        rd_data
);

    opa_opc_e               opc;
    logic                   accept;
    logic                   take_upd;
    logic                   take_read;
    logic                   grid_valid;
    logic                   grid_clear;
    logic [N*N-1:0][AW-1:0] grid_dot;
    logic [N*N-1:0][AW-1:0] acc_q;
    logic                   rd_last;

    assign opc = opa_opc_e'(cmd_op);

    // Open the port unless an update is in flight or rows 0..N-2 are streaming.
    assign cmd_ready = !grid_valid && (!rd_valid || rd_last);

    // Classify the command accepted this cycle.
    always_comb begin
        accept    = cmd_valid && cmd_ready;
        take_upd  = accept && ((opc == OPC_ZERO_ADD) || (opc == OPC_ADD));
        take_read = accept && (opc == OPC_READ);
    end

    opa_grid_stage #(
        .N  (N),
        .EW (EW),
        .AW (AW)
    ) u_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_upd),
        .clear_i (opc == OPC_ZERO_ADD),
        .x_i     (cmd_x),
        .y_i     (cmd_y),
        .valid_o (grid_valid),
        .clear_o (grid_clear),
        .dot_o   (grid_dot)
    );

    opa_acc_bank #(
        .N  (N),
        .AW (AW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (grid_valid),
        .clear_i (grid_clear),
        .dot_i   (grid_dot),
        .acc_o   (acc_q)
    );

    opa_readout #(
        .N  (N),
        .AW (AW)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (take_read),
        .acc_i    (acc_q),
        .active_o (rd_valid),
        .last_o   (rd_last),
        .row_o    (rd_row),
        .data_o   (rd_data)
    );

endmodule

// File: rtl/opa_mac_unit_chk.sv
// Module: protocol checker for opa_mac_unit, attached by bind. Observes
// ports only; assumes the N default of the unit it is bound to.
module opa_mac_unit_chk #(
    parameter int unsigned N = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [1:0]           cmd_op,
    input logic                 rd_valid,
    input logic [$clog2(N)-1:0] rd_row
);

    localparam int unsigned RW        = $clog2(N);
    localparam logic [RW-1:0] LASTROW = RW'(N - 1);

    // R1: reset leaves the port open and no stream running.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && cmd_ready));

    // R6: an accepted update closes the port for the next cycle.
    p_update_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_op[1]) |=> !cmd_ready);

    // R6: the port reopens two cycles after an accepted update.
    p_update_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_op[1]) |=> ##1 cmd_ready);

    // R7: an accepted read starts at row 0.
    p_read_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> (rd_valid && rd_row == '0));

    // R7: rows follow one another without gaps.
    p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_row != LASTROW) |=> (rd_valid && rd_row == RW'($past(rd_row) + 1'b1)));

    // R8: the port stays closed before the final row.
    p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_row != LASTROW) |-> !cmd_ready);

    // R9: a no-operation command starts nothing.
    p_nop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> (!rd_valid && cmd_ready));

endmodule

bind opa_mac_unit opa_mac_unit_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rd_valid  (rd_valid),
    .rd_row    (rd_row)
);

// File: tb/tb_opa_mac_unit.sv
`timescale 1ns/1ps
// Bench: sweeps operand patterns through opa_mac_unit and compares each
// read-out element with an arithmetic model kept in the bench.
module tb_opa_mac_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = 2'd0;
    logic [127:0] cmd_x = '0;
    logic [127:0] cmd_y = '0;
    logic         rd_valid;
    logic [1:0]   rd_row;
    logic [127:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model [16];

    always #2.5 clk = ~clk;

    opa_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y),
        .rd_valid(rd_valid), .rd_row(rd_row), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] put(input logic [127:0] v, input int g, input int k, input int val);
        logic [127:0] r = v;
        r[8*(4*g+k) +: 8] = val[7:0];
        return r;
    endfunction

    function automatic int elem(input logic [127:0] v, input int g, input int k);
        int s = $signed(v[8*(4*g+k) +: 8]);
        return s;
    endfunction

    function automatic logic [31:0] dotp(input logic [127:0] x, input logic [127:0] y, input int i, input int j);
        int s = 0;
        for (int k = 0; k < 4; k++) s = s + elem(x, i, k) * elem(y, j, k);
        return s;
    endfunction

    // Issue one command starting at a falling edge; returns at a falling edge.
    task automatic apply(input logic [1:0] op, input logic [127:0] x, input logic [127:0] y);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_x = x; cmd_y = y;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op <= 2'd1) begin
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    model[i*4+j] = ((op == 2'd0) ? 32'd0 : model[i*4+j]) + dotp(x, y, i, j);
            check("R6 ready low after update", {31'd0, cmd_ready}, 32'd0);
        end
    endtask

    // Read all rows and compare; returns at the falling edge of row 3.
    task automatic read_all(input string req);
        apply(2'd2, '0, '0);
        for (int r = 0; r < 4; r++) begin
            if (r > 0) @(negedge clk);
            check("R7 rd_valid", {31'd0, rd_valid}, 32'd1);
            check("R7 rd_row", {30'd0, rd_row}, r);
            check("R8 ready during stream", {31'd0, cmd_ready}, (r == 3) ? 32'd1 : 32'd0);
            for (int j = 0; j < 4; j++)
                check(req, rd_data[32*j +: 32], model[r*4+j]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] x, y;
        for (int e = 0; e < 16; e++) model[e] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while held in reset
        check("R1 ready in reset", {31'd0, cmd_ready}, 32'd1);
        check("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 zero after reset");

        // R2: one-hot byte position sweep
        for (int g = 0; g < 4; g++)
            for (int k = 0; k < 4; k++) begin
                x = put('0, g, k, (g == 1) ? -3 : 3);
                y = '0;
                for (int j = 0; j < 4; j++)
                    for (int kk = 0; kk < 4; kk++) y = put(y, j, kk, 4*j + kk + 1 - 8);
                apply(2'd0, x, y);
                read_all("R2 byte position");
            end

        // R3: signed pattern sweep with clear-and-add
        for (int v = -128; v < 128; v += 5) begin
            x = '0; y = '0;
            for (int g = 0; g < 4; g++)
                for (int k = 0; k < 4; k++) begin
                    x = put(x, g, k, v + 7*g - 3*k);
                    y = put(y, g, k, 127 - v - 11*g + 5*k);
                end
            apply(2'd0, x, y);
            read_all("R3 clear and add");
        end

        // R4: running accumulation over several steps
        for (int s = 0; s < 12; s++) begin
            x = '0; y = '0;
            for (int g = 0; g < 4; g++)
                for (int k = 0; k < 4; k++) begin
                    x = put(x, g, k, 13*s - 9*g + 17*k - 60);
                    y = put(y, g, k, -7*s + 23*g - 5*k + 40);
                end
            apply((s == 0) ? 2'd0 : 2'd1, x, y);
            read_all("R4 accumulate");
        end

        // R10: a valid pulse while the port is closed is ignored
        apply(2'd1, {16{8'h05}}, {16{8'hFD}});
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_x = {16{8'h7F}}; cmd_y = {16{8'h7F}};
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        read_all("R10 ignored while not ready");

        // R9: no-operation changes nothing and starts no stream
        apply(2'd3, {16{8'h11}}, {16{8'h22}});
        check("R9 no stream after nop", {31'd0, rd_valid}, 32'd0);
        check("R9 ready after nop", {31'd0, cmd_ready}, 32'd1);
        read_all("R9 nop keeps values");
        read_all("R9 read keeps values");

        // R8: update accepted in the row-3 cycle is applied once
        apply(2'd1, {16{8'h80}}, {16{8'h01}});
        read_all("R8 update during last row");

        // R5: wrap past the signed 32-bit limit
        apply(2'd0, {16{8'h80}}, {16{8'h80}});
        for (int s = 1; s < 32768; s++) apply(2'd1, {16{8'h80}}, {16{8'h80}});
        read_all("R5 wrap to minimum");
        check("R5 model at minimum", model[0], 32'h8000_0000);
        apply(2'd1, {16{8'h80}}, {16{8'h80}});
        read_all("R5 after wrap");

        // R1: reset in the middle of a run clears the accumulators
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < 16; e++) model[e] = '0;
        @(negedge clk);
        read_all("R1 zero after mid-run reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule